// File: doc/BRIEF.md
# Windowed ADC Capture

This block sits between an analog-to-digital converter and a frequency-domain stage. It divides the system clock down to produce the converter's sampling clock. After a sweep-start request it takes one converter word per sampling period until 2048 words have been taken. Each word is re-centred to a signed value and multiplied by a Hamming weight. The product is rounded to a 12-bit signed result and presented to a frame buffer together with its sample number and a write strobe.

Only half of the symmetric Hamming curve is held in a table of 1024 ten-bit weights. The second half of the frame reads that table in reverse order. When the write of the last sample has been issued, a single-cycle start pulse tells the transform stage that the buffer is full. Words that arrive after the frame is complete are not taken until the next sweep-start request.

Top module: `win_capture`

## Requirements
- R1: `adc_clk` is a square wave with a period of 2·DIV_HALF system clocks. It is high for the first DIV_HALF cycles of each period and low for the rest. An accepted sweep start restarts the period: `adc_clk` is high in the cycle after the arming edge.
- R2: `sweep_go` sampled high while no capture is running arms a capture. The first word is taken from `adc_data` at the 2·DIV_HALF-th rising edge after the arming edge. Later words are taken every 2·DIV_HALF cycles, and the first write strobe is visible one cycle after the first word is taken.
- R3: `adc_data` is offset binary. The signed sample is s = code − 1024, so code 1024 is zero, code 0 is −1024 and code 2047 is +1023.
- R4: The weight for sample number n is c(n) = round(1023·(0.54 − 0.46·cos(2πn/2047))). It is stored for n = 0..1023 only. For n ≥ 1024 the weight of entry 2047 − n is used.
- R5: `wr_data` = floor((s·c(n) + 256) / 512), saturated to the range −2048..2047.
- R6: Each taken word gives exactly one single-cycle `wr_en` pulse, one clock after the word is taken. `wr_idx` carries the sample numbers 0, 1, …, 2047 in order.
- R7: `fft_go` is a one-cycle pulse in the cycle right after the `wr_en` pulse with `wr_idx` = 2047, and at no other time.
- R8: After 2048 words, no further `wr_en` pulses occur until the next accepted sweep start. A `sweep_go` that arrives while a capture is running is ignored, and numbering continues without a break.
- R9: While `rst_n` is low, `wr_en`, `fft_go` and `adc_clk` are low. After reset no write occurs without a sweep start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_go | input | 1 | Sweep start request; arms one frame capture |
| adc_data | input | 11 | Converter word, offset binary |
| adc_clk | output | 1 | Generated sampling clock for the converter |
| wr_en | output | 1 | Frame buffer write strobe |
| wr_idx | output | 11 | Sample number of the value being written |
| wr_data | output | 12 | Windowed, rounded signed sample |
| fft_go | output | 1 | Frame-complete pulse for the transform stage |

## Verification
Counted from the arming edge, `adc_clk` is high from the first following cycle. The first word is taken at edge 2·DIV_HALF and its strobe is seen after edge 2·DIV_HALF+1. Each later strobe follows one sampling period after the previous one, and `fft_go` follows the last strobe by exactly one cycle. The bench samples every output on the falling edge. It counts falling edges from the arming edge and compares the cycle count, the clock level and each strobe's number and value against those offsets. A check that a stimulus has no effect is made by watching the strobe over several sampling periods that follow it.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  localparam int ADC_W  = 11;
  localparam int COEF_W = 10;
  localparam int OUT_W  = 12;
  localparam int PROD_W = ADC_W + COEF_W + 1;
  localparam int SHIFT  = COEF_W - 1;

  // Hamming weight, scaled to full COEF_W range, evaluated at elaboration
  function automatic int win_coef(int k, int frame);
    real th;
    real w;
    th = 2.0 * 3.14159265358979 * real'(k) / real'(frame - 1);
    w  = 0.54 - 0.46 * $cos(th);
    return $rtoi(w * real'((1 << COEF_W) - 1) + 0.5);
  endfunction

  // offset binary -> two's complement: flip the top bit
  function automatic logic signed [ADC_W-1:0] center(logic [ADC_W-1:0] code);
    return {~code[ADC_W-1], code[ADC_W-2:0]};
  endfunction

  // add half an output LSB, shift down, clamp to OUT_W signed
  function automatic logic signed [OUT_W-1:0] round_sat(logic signed [PROD_W-1:0] p);
    logic signed [PROD_W-1:0] q;
    logic signed [PROD_W-1:0] hi;
    logic signed [PROD_W-1:0] lo;
    hi = PROD_W'((1 << (OUT_W - 1)) - 1);
    lo = -PROD_W'(1 << (OUT_W - 1));
    q  = (p + PROD_W'(1 << (SHIFT - 1))) >>> SHIFT;
    if (q > hi)      return OUT_W'(hi);
    else if (q < lo) return OUT_W'(lo);
    else             return OUT_W'(q);
  endfunction
endpackage

// File: rtl/wcap_clkgen.sv
module wcap_clkgen #(
  parameter int DIV_HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic adc_clk,
  output logic tick
);
  localparam int PER = 2 * DIV_HALF;
  localparam int CW  = $clog2(PER);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  assign tick = (cnt == CW'(PER - 1));

  always_comb begin
    if (restart || tick) cnt_nx = '0;
    else                 cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= CW'(PER - 1);
      adc_clk <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      adc_clk <= (cnt_nx < CW'(DIV_HALF));
    end
  end

  // R1
  clk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_clk) |-> cnt == CW'(DIV_HALF));

  // R2
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> adc_clk && cnt == '0);
endmodule

// File: rtl/wcap_coef_rom.sv
module wcap_coef_rom
  import wcap_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [COEF_W-1:0] coef
);
  localparam int FRAME = 1 << IDX_W;
  localparam int HALF  = FRAME / 2;

  logic [COEF_W-1:0] tbl [HALF];
  logic [IDX_W-2:0]  addr;

  for (genvar k = 0; k < HALF; k++) begin : g_tbl
    localparam logic [COEF_W-1:0] CV = COEF_W'(win_coef(k, FRAME));
    assign tbl[k] = CV;
  end

  // upper half of the frame mirrors: FRAME-1-n equals n with low bits inverted
  assign addr = idx[IDX_W-1] ? ~idx[IDX_W-2:0] : idx[IDX_W-2:0];
  assign coef = tbl[addr];
endmodule

// File: rtl/wcap_scale.sv
module wcap_scale
  import wcap_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [ADC_W-1:0]        in_code,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [COEF_W-1:0]       coef,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic signed [OUT_W-1:0] wr_data
);
  localparam logic [ADC_W-1:0] MID = ADC_W'(1 << (ADC_W - 1));

  logic signed [ADC_W-1:0]  samp;
  logic signed [PROD_W-1:0] samp_x;
  logic signed [PROD_W-1:0] coef_x;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    samp   = center(in_code);
    samp_x = PROD_W'(samp);
    coef_x = PROD_W'({1'b0, coef});
    prod   = samp_x * coef_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= in_valid;
      if (in_valid) begin
        wr_idx  <= in_idx;
        wr_data <= round_sat(prod);
      end
    end
  end

  // R5
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_code == MID |=> wr_en && wr_data == '0);

  // R3
  sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_code < MID |=> wr_en && wr_data <= 0);
endmodule

// File: rtl/win_capture.sv
module win_capture
  import wcap_pkg::*;
#(
  parameter int DIV_HALF = 25,
  parameter int IDX_W    = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sweep_go,
  input  logic [ADC_W-1:0]        adc_data,
  output logic                    adc_clk,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic signed [OUT_W-1:0] wr_data,
  output logic                    fft_go
);
  localparam logic [IDX_W-1:0] LAST = '1;

  logic                   capturing;
  logic [IDX_W-1:0]       idx_cnt;
  logic                   arm_accept;
  logic                   tick;
  logic                   cap_take;
  logic                   s1_valid;
  logic [ADC_W-1:0]       s1_code;
  logic [IDX_W-1:0]       s1_idx;
  logic [COEF_W-1:0]      coef;

  assign arm_accept = sweep_go && !capturing;
  assign cap_take   = capturing && tick;

  wcap_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (arm_accept),
    .adc_clk (adc_clk),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capturing <= 1'b0;
      idx_cnt   <= '0;
      s1_valid  <= 1'b0;
      s1_code   <= '0;
      s1_idx    <= '0;
      fft_go    <= 1'b0;
    end else begin
      if (arm_accept) begin
        capturing <= 1'b1;
        idx_cnt   <= '0;
      end else if (cap_take) begin
        idx_cnt <= idx_cnt + 1'b1;
        if (idx_cnt == LAST) capturing <= 1'b0;
      end
      s1_valid <= cap_take;
      if (cap_take) begin
        s1_code <= adc_data;
        s1_idx  <= idx_cnt;
      end
      fft_go <= wr_en && (wr_idx == LAST);
    end
  end

  wcap_coef_rom #(.IDX_W(IDX_W)) u_rom (
    .idx  (s1_idx),
    .coef (coef)
  );

  wcap_scale #(.IDX_W(IDX_W)) u_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s1_valid),
    .in_code  (s1_code),
    .in_idx   (s1_idx),
    .coef     (coef),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  // R6
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R7
  start_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fft_go |-> $past(wr_en) && $past(wr_idx) == LAST);

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(capturing) |-> s1_valid && s1_idx == LAST);

  // R8
  idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capturing |=> !s1_valid);
endmodule

// File: tb/win_capture_bench.sv
module win_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_T     = 2;
  localparam int PER        = 2 * HALF_T;
  localparam int NFRAME     = 2048;
  localparam int NROW       = 6;
  // stimulus code, expected output for sample number 0, re-arm mid frame
  localparam int ROWS [NROW][3] = '{
    '{0,    -164, 0},
    '{2047,  164, 0},
    '{1024,    0, 1},
    '{1025,    0, 0},
    '{1023,    0, 0},
    '{1500,   76, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sweep_go = 1'b0;
  logic [10:0] adc_data = 11'd1024;
  logic adc_clk;
  logic wr_en;
  logic [10:0] wr_idx;
  logic signed [11:0] wr_data;
  logic fft_go;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit armed_exp = 1'b0;
  bit prev_last = 1'b0;
  int mon_idx = 0;
  int mon_code = 1024;
  int first_val = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  win_capture #(.DIV_HALF(HALF_T), .IDX_W(11)) u_win_capture (
    .clk(clk), .rst_n(rst_n), .sweep_go(sweep_go), .adc_data(adc_data),
    .adc_clk(adc_clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fft_go(fft_go)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // weight taken straight over the full frame, no mirroring (R4), centred code (R3)
  function automatic int model_y(int n, int code);
    real cr;
    real yr;
    int c;
    int y;
    cr = 1023.0 * (0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * real'(n) / 2047.0));
    c  = int'($floor(cr + 0.5));
    yr = $floor(real'((code - 1024) * c) / 512.0 + 0.5);
    y  = int'(yr);
    if (y > 2047) y = 2047;
    if (y < -2048) y = -2048;
    return y;
  endfunction

  // write monitor: numbering, values, start pulse, stray writes
  always @(negedge clk) begin
    if (rst_n) begin
      if (fft_go || prev_last) chk(fft_go == prev_last, "R7 start pulse", int'(fft_go), int'(prev_last));
      prev_last = wr_en && (wr_idx == 11'd2047);
      if (wr_en) begin
        if (!armed_exp) begin
          chk(1'b0, "R8 stray write", int'(wr_idx), -1);
        end else begin
          chk(int'(wr_idx) == mon_idx, "R6 index order", int'(wr_idx), mon_idx);
          // R4 and R3 enter through model_y
          chk(int'(wr_data) == model_y(mon_idx, mon_code), "R5 value",
              int'(wr_data), model_y(mon_idx, mon_code));
          if (mon_idx == 0) first_val = int'(wr_data);
          if (mon_idx == NFRAME - 1) armed_exp = 1'b0;
          mon_idx++;
        end
      end
    end
  end

  task automatic run_frame(input int code, input int exp0, input bit rearm);
    int k;
    adc_data  = 11'(code);
    mon_code  = code;
    mon_idx   = 0;
    armed_exp = 1'b1;
    sweep_go  = 1'b1;
    @(negedge clk);
    sweep_go = 1'b0;
    k = 0;
    while (!wr_en && k < 50) begin
      if (k < 2 * PER) chk(adc_clk == ((k % PER) < HALF_T), "R1 clock level", int'(adc_clk), int'((k % PER) < HALF_T));
      @(negedge clk);
      k++;
    end
    chk(k == PER + 1, "R2 first write latency", k, PER + 1);
    @(negedge clk);
    chk(first_val == exp0, "R3 first value", first_val, exp0);
    if (rearm) begin
      repeat (3000) @(negedge clk);
      sweep_go = 1'b1;   // R8: must be ignored mid frame
      @(negedge clk);
      sweep_go = 1'b0;
    end
    while (armed_exp) @(negedge clk);
    chk(mon_idx == NFRAME, "R6 write count", mon_idx, NFRAME);
    begin
      int extra = 0;
      repeat (10 * PER) begin
        @(negedge clk);
        if (wr_en) extra++;
      end
      chk(extra == 0, "R8 writes after frame", extra, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en, "R9 reset wr_en", int'(wr_en), 0);
    chk(!fft_go, "R9 reset fft_go", int'(fft_go), 0);
    chk(!adc_clk, "R9 reset adc_clk", int'(adc_clk), 0);
    rst_n = 1'b1;
    begin
      int w = 0;
      repeat (20) begin
        @(negedge clk);
        if (wr_en) w++;
      end
      chk(w == 0, "R9 no write unarmed", w, 0);
    end
    for (int r = 0; r < NROW; r++) run_frame(ROWS[r][0], ROWS[r][1], ROWS[r][2] != 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule